// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a byte-wide NOR flash with sixteen erasable blocks. A host writes command bytes over an SRAM-style strobe bus. A falling and then rising write enable, with chip enable held low, hands one byte and one address to the decoder. Reads on the same address bus return one of three things, chosen by the current read mode: array contents, identifier codes, or an 8-bit status word.

Erase and byte write are two-cycle sequences. A write state machine runs each one for a fixed number of clock cycles. It pulls `ready` low while it works, and an erase can be paused and resumed. The status word holds sticky error flags. These are:
- a flag for a bad command sequence;
- a flag for a program voltage found low when a sequence completes;
- a lockout flag that blocks later operations until software clears it.

The array is a behavioural register file. It holds `2**OFF_W` bytes per block, so addresses that differ only in the middle bits read and write the same byte.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and the read mode is array. Every array byte reads FFh, and the status word reads 80h.
- R2: A command is taken when `we_n` rises after a cycle in which both `we_n` and `ce_n` were low. A `we_n` pulse with `ce_n` high changes nothing.
- R3: Command 90h selects identifier mode. Address bit 0 = 0 returns ID_MAKER (5Ah) and bit 0 = 1 returns ID_PART (C3h). Command FFh returns to array mode.
- R4: Byte write is 40h or 10h, followed by a cycle that carries the data and the target address. `ready` is then low for exactly WRITE_CYC clock cycles, and the stored byte becomes old AND new.
- R5: Erase is 20h followed by D0h at an address inside the same block (block = address bits 19:16). `ready` goes low. At completion every byte of that block reads FFh, and other blocks are unchanged.
- R6: If an erase setup is followed by any byte other than D0h, status bits 5 and 4 are set and nothing is erased. Command 50h clears bits 5, 4 and 3.
- R7: The status word has these fields:
  - bit 7 = ready;
  - bit 6 = erase suspended;
  - bit 5 = erase error;
  - bit 4 = write error;
  - bit 3 = low program voltage;
  - bits 2:0 = 0.
  Command 70h selects status mode. An erase or write setup also switches reads to status.
- R8: While an erase or write is running, command FFh is ignored and reads stay in status mode.
- R9: If `vpp_ok` is low when the second cycle of an erase or write arrives, the operation does not start. `ready` stays 1, bit 3 is set, and the array is unchanged.
- R10: While bit 3 is set, completed erase or write sequences do not run. Once a 50h clears the bit, they run again.
- R11: Command B0h during an erase suspends it. `ready` goes high, bit 6 reads 1, and FFh then gives array reads. D0h resumes the erase, clears bit 6, and the erase then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also models leaving deep power-down |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; command taken on its rise |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Command or data byte |
| vpp_ok | input | 1 | Program voltage good |
| dout | output | 8 | Read data for the current mode |
| ready | output | 1 | 1 when the state machine is idle or suspended |

## Verification
The bench goes after the sequences a decoder most easily gets wrong.
- **Strobe with chip enable high.** A decoder that ignores `ce_n` would jump to identifier mode.
- **FFh sent mid-operation.** If honoured, later reads would show array data instead of status.
- **Bad erase confirm.** A design that treats it as a plain command would leave bits 5 and 4 clear.
- **Erase suspend and resume.** A wrong counter would complete early or leave the block intact.
- **Low-voltage abort and the lockout after it.** A broken design lets the next write modify the array before 50h clears the flag.
- **Byte-write result.** The bench checks it as an AND of old and new data, which catches a plain overwrite.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W = 20,
  parameter int BLK_W = 4,
  parameter int OFF_W = 2,
  parameter int ERASE_CYC = 40,
  parameter int WRITE_CYC = 8,
  parameter logic [7:0] ID_MAKER = 8'h5A,
  parameter logic [7:0] ID_PART = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              vpp_ok,
  output logic [7:0]        dout,
  output logic              ready
);
  localparam int DEPTH = 1 << OFF_W;
  localparam int WORDS = (1 << BLK_W) * DEPTH;
  localparam int IDX_W = BLK_W + OFF_W;
  localparam int MAXC  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [7:0] C_READ = 8'hFF, C_IDENT = 8'h90, C_STAT = 8'h70,
                         C_CLR = 8'h50, C_ERASE = 8'h20, C_CONF = 8'hD0,
                         C_PROG = 8'h40, C_PROG2 = 8'h10, C_SUSP = 8'hB0;

  typedef enum logic [1:0] {RD_ARR, RD_ID, RD_ST} rmode_t;
  typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_WRITE} pend_t;
  typedef enum logic [1:0] {WS_IDLE, WS_ERASE, WS_WRITE, WS_SUSP} wsm_t;

  rmode_t rmode;
  pend_t pend;
  wsm_t wsm;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] op_blk;
  logic [IDX_W-1:0] op_idx;
  logic [7:0] op_data;
  logic sr_ers, sr_wr, sr_vpp, we_arm;
  logic [7:0] mem [WORDS];

  wire unused_addr = ^addr[ADDR_W-BLK_W-1:OFF_W];
  wire [BLK_W-1:0] blk = addr[ADDR_W-1 -: BLK_W];
  wire [IDX_W-1:0] idx = {blk, addr[OFF_W-1:0]};
  wire commit = we_arm && we_n;
  wire busy = (wsm == WS_ERASE) || (wsm == WS_WRITE);
  wire [7:0] status = {!busy, wsm == WS_SUSP, sr_ers, sr_wr, sr_vpp, 3'b000};

  assign ready = !busy;

  always_comb begin
    case (rmode)
      RD_ARR:  dout = mem[idx];
      RD_ID:   dout = addr[0] ? ID_PART : ID_MAKER;
      default: dout = status;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_arm <= 1'b0;
    else        we_arm <= !ce_n && !we_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rmode <= RD_ARR;
      pend <= PD_NONE;
      wsm <= WS_IDLE;
      cnt <= '0;
      op_blk <= '0;
      op_idx <= '0;
      op_data <= '0;
      sr_ers <= 1'b0;
      sr_wr <= 1'b0;
      sr_vpp <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;
    end else begin
      if (busy) begin
        if (cnt == '0) begin
          if (wsm == WS_ERASE)
            for (int i = 0; i < DEPTH; i++) mem[{op_blk, OFF_W'(i)}] <= 8'hFF;
          else
            mem[op_idx] <= mem[op_idx] & op_data;
          wsm <= WS_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (commit) begin
        if (busy) begin
          if (din == C_STAT) rmode <= RD_ST;
          else if (din == C_SUSP && wsm == WS_ERASE && cnt != '0) begin
            wsm <= WS_SUSP;
            rmode <= RD_ST;
          end
        end else if (pend == PD_ERASE) begin
          pend <= PD_NONE;
          rmode <= RD_ST;
          if (din != C_CONF) begin
            sr_ers <= 1'b1;
            sr_wr <= 1'b1;
          end else if (!sr_vpp) begin
            if (!vpp_ok) sr_vpp <= 1'b1;
            else begin
              wsm <= WS_ERASE;
              op_blk <= blk;
              cnt <= CNT_W'(ERASE_CYC - 1);
            end
          end
        end else if (pend == PD_WRITE) begin
          pend <= PD_NONE;
          rmode <= RD_ST;
          if (!sr_vpp) begin
            if (!vpp_ok) sr_vpp <= 1'b1;
            else begin
              wsm <= WS_WRITE;
              op_idx <= idx;
              op_data <= din;
              cnt <= CNT_W'(WRITE_CYC - 1);
            end
          end
        end else if (wsm == WS_SUSP) begin
          case (din)
            C_CONF: begin wsm <= WS_ERASE; rmode <= RD_ST; end
            C_READ: rmode <= RD_ARR;
            C_IDENT: rmode <= RD_ID;
            C_STAT: rmode <= RD_ST;
            default: ;
          endcase
        end else begin
          case (din)
            C_READ: rmode <= RD_ARR;
            C_IDENT: rmode <= RD_ID;
            C_STAT: rmode <= RD_ST;
            C_CLR: begin sr_ers <= 1'b0; sr_wr <= 1'b0; sr_vpp <= 1'b0; end
            C_ERASE: begin pend <= PD_ERASE; rmode <= RD_ST; end
            C_PROG, C_PROG2: begin pend <= PD_WRITE; rmode <= RD_ST; end
            default: ;
          endcase
        end
      end
    end
  end

  // R4
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(commit));

  // R9
  vpp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !busy && pend == PD_WRITE && !sr_vpp && !vpp_ok) |=> (ready && sr_vpp));

  // R6
  bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !busy && pend == PD_ERASE && din != C_CONF) |=> (sr_ers && sr_wr && ready));

  // R10
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !busy && pend != PD_NONE && sr_vpp) |=> ready);

  // R5
  erase_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wsm == WS_ERASE && cnt == '0) |=> (mem[{op_blk, {OFF_W{1'b0}}}] == 8'hFF));
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, vpp_ok = 1;
  logic [19:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic ready;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  localparam int WCYC = 8;
  localparam int ECYC = 40;

  flash_cmd_ctrl #(.ERASE_CYC(ECYC), .WRITE_CYC(WCYC)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .din(din), .vpp_ok(vpp_ok), .dout(dout), .ready(ready));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [19:0] a, input logic [7:0] d, input bit sel = 1);
    @(negedge clk);
    ce_n = !sel; addr = a; din = d; we_n = 0;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    ce_n = 1;
  endtask

  task automatic rd(input logic [19:0] a, input logic [7:0] e, input string tag);
    @(posedge clk);
    #1;
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) check(tag_q.pop_front(), dout, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after reset", {7'b0, ready}, 8'h01);
    rd(20'h00000, 8'hFF, "R1 array erased");
    rd(20'h3F002, 8'hFF, "R1 array erased high block");
    bus_wr(20'h0, 8'h70);
    rd(20'h0, 8'h80, "R1 R7 status after reset");
    bus_wr(20'h0, 8'hFF);
    bus_wr(20'h0, 8'h90, 0);
    rd(20'h0, 8'hFF, "R2 strobe with ce_n high ignored");
    bus_wr(20'h0, 8'h90);
    rd(20'h0, 8'h5A, "R3 maker id");
    rd(20'h1, 8'hC3, "R3 part id");
    bus_wr(20'h0, 8'hFF);
    rd(20'h1, 8'hFF, "R3 back to array");

    bus_wr(20'h10001, 8'h40);
    rd(20'h10001, 8'h80, "R7 setup switches to status");
    bus_wr(20'h10001, 8'hA5);
    wait_ready(n);
    check("R4 write busy cycles", 8'(n), 8'(WCYC));
    rd(20'h0, 8'h80, "R7 status ready after write");
    bus_wr(20'h0, 8'hFF);
    rd(20'h10001, 8'hA5, "R4 byte written");
    bus_wr(20'h10001, 8'h10);
    bus_wr(20'h10001, 8'h0F);
    bus_wr(20'h0, 8'hFF);
    rd(20'h0, 8'h00, "R8 FFh while busy keeps status");
    wait_ready(n);
    rd(20'h0, 8'h80, "R8 status mode kept after completion");
    bus_wr(20'h0, 8'hFF);
    rd(20'h10001, 8'h05, "R4 AND of old and new");
    bus_wr(20'h20000, 8'h40);
    bus_wr(20'h20000, 8'h3C);
    wait_ready(n);

    bus_wr(20'h10000, 8'h20);
    bus_wr(20'h1FFFF, 8'hD0);
    check("R5 ready low during erase", {7'b0, ready}, 8'h00);
    bus_wr(20'h0, 8'hB0);
    check("R11 ready high when suspended", {7'b0, ready}, 8'h01);
    rd(20'h0, 8'hC0, "R11 suspend status");
    bus_wr(20'h0, 8'hFF);
    rd(20'h20000, 8'h3C, "R11 array read while suspended");
    rd(20'h10001, 8'h05, "R11 block not yet erased");
    bus_wr(20'h0, 8'hD0);
    check("R11 ready low after resume", {7'b0, ready}, 8'h00);
    rd(20'h0, 8'h00, "R11 resume clears suspend bit");
    wait_ready(n);
    bus_wr(20'h0, 8'hFF);
    rd(20'h10001, 8'hFF, "R5 erased byte");
    rd(20'h10000, 8'hFF, "R5 erased byte 0");
    rd(20'h20000, 8'h3C, "R5 other block intact");

    bus_wr(20'h20000, 8'h20);
    bus_wr(20'h20000, 8'h77);
    check("R6 no erase started", {7'b0, ready}, 8'h01);
    rd(20'h0, 8'hB0, "R6 bits 5 and 4 set");
    bus_wr(20'h0, 8'h50);
    rd(20'h0, 8'h80, "R6 clear status");
    bus_wr(20'h0, 8'hFF);
    rd(20'h20000, 8'h3C, "R6 block not erased");

    vpp_ok = 0;
    bus_wr(20'h20000, 8'h40);
    bus_wr(20'h20000, 8'h00);
    check("R9 ready stays high", {7'b0, ready}, 8'h01);
    rd(20'h0, 8'h88, "R9 vpp bit set");
    vpp_ok = 1;
    bus_wr(20'h0, 8'hFF);
    rd(20'h20000, 8'h3C, "R9 array unchanged");

    bus_wr(20'h20000, 8'h40);
    bus_wr(20'h20000, 8'h00);
    check("R10 locked write not started", {7'b0, ready}, 8'h01);
    rd(20'h0, 8'h88, "R10 vpp bit still set");
    bus_wr(20'h0, 8'hFF);
    rd(20'h20000, 8'h3C, "R10 array unchanged");
    bus_wr(20'h0, 8'h50);
    bus_wr(20'h0, 8'h70);
    rd(20'h0, 8'h80, "R10 cleared status");
    bus_wr(20'h20000, 8'h40);
    bus_wr(20'h20000, 8'h00);
    wait_ready(n);
    check("R10 write runs after clear", 8'(n), 8'(WCYC));
    bus_wr(20'h0, 8'hFF);
    rd(20'h20000, 8'h00, "R10 byte written after clear");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule